// File: doc/BRIEF.md
# Pipelined Extension-Bus Register Slave

This block sits on the device end of a short synchronous extension bus from a host processor. It gives a user peripheral a bank of 32 sixteen-bit registers. The host selects the device with two select-code bits and an active-low select. It forms a 5-bit register number from a 4-bit upper group and a separate least significant address line, and chooses a direction bit. Every transfer completes on the rising edge of the bus clock. That clock rests high and only pulses while the device is selected.

Writes take effect on the selected edge. Reads are pipelined: during a selected read cycle the device drives the word held in the register named in the previous selected cycle. The data bus numbers its bits in reverse, so bus bit 15 carries the least significant bit of the stored word. Register 0 absorbs writes without change, because the host issues such writes as a by-product of other work. When the bus is shared with other adapters, upper address groups 2 and 3 belong to those adapters, and status line 1 is left to them. The four status outputs show the low bits of a status register. The interrupt output is held inactive.

Top module: `xbus_reg_slave`

## Requirements
- R1: After reset, every register reads as 0, all four status outputs are 0 and the data driver is off.
- R2: The device is selected only when devSel is 2'b00 and selN is 0. In any other cycle it changes no register and does not drive data (dataOe 0, dataOut 0).
- R3: The register number is {addrHi, addrLo}, with addrLo as bit 0. Registers 8 and 9 are distinct.
- R4: Bus bit 15 is logical bit 0 of a register word, and in general bus bit k is logical bit 15-k, in both directions.
- R5: During a selected cycle with dirRead 1, dataOut carries the register named in the previous selected cycle, with the contents it held at the start of the current cycle.
- R6: dataOe is 1 only in a selected read cycle that has at least one earlier selected cycle since reset, and only when that earlier address is not reserved. It drops in the same cycle that select is removed.
- R7: A selected write to register 0 changes no state, and register 0 always reads as 0.
- R8: With SHARE_EN set, addresses whose upper group addrHi is 2 or 3 (registers 4 to 7) ignore writes. A read cycle whose previous address lies in that range leaves the driver off.
- R9: statusOut[i] equals logical bit i of register 1 (STATUS_ADDR). With SHARE_EN set, statusOut[1] is held at 0.
- R10: irqN is 1 at all times, during and after reset.
- R11: A selected cycle with dirRead 0 to a non-zero, non-reserved address stores the bit-reversed dataIn into that register on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 16 | Bus data from host (bit 15 = LSB) |
| dataOut | output | 16 | Read data to bus (bit 15 = LSB), 0 when not driving |
| dataOe | output | 1 | Tri-state enable for dataOut |
| addrHi | input | 4 | Upper four register-number bits |
| addrLo | input | 1 | Register-number bit 0 |
| dirRead | input | 1 | 1 = device to host, 0 = host to device |
| devSel | input | 2 | Select code, device chosen at 2'b00 |
| selN | input | 1 | Active-low select |
| statusOut | output | 4 | Status lines to host |
| irqN | output | 1 | Interrupt, active low, held high |

## Verification
The assertions check four rules on every cycle. The driver is only ever on during a selected read. It stays off with a zero bus after unselected cycles and after a reserved previous address. Status line 1 stays low while sharing is enabled. The status lines do not move after unselected cycles or writes to register 0. The bench scenarios are needed to show the data content itself: that a read returns the previous cycle's register, that bus bits are reversed, that 8 and 9 differ, and that reset clears the bank. They also show that the first read after reset is not driven.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_DATA_W   = 16;
  localparam int XB_ADDR_HI_W = 4;
  localparam int XB_ADDR_W   = XB_ADDR_HI_W + 1;
  localparam int XB_NUM_REGS = 1 << XB_ADDR_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [XB_ADDR_W-1:0] wrAddr;
    logic [XB_ADDR_W-1:0] rdAddr;
    logic                 drive;
  } xbStrobes_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter bit SHARE_EN = 1'b1,
  parameter int RSV_LO   = 2,
  parameter int RSV_HI   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [XB_ADDR_HI_W-1:0] addrHi,
  input  logic                    addrLo,
  input  logic                    dirRead,
  input  logic [1:0]              devSel,
  input  logic                    selN,
  output xbStrobes_t              strobes
);
  localparam logic [XB_ADDR_HI_W-1:0] RSV_LO_V = XB_ADDR_HI_W'(RSV_LO);
  localparam logic [XB_ADDR_HI_W-1:0] RSV_HI_V = XB_ADDR_HI_W'(RSV_HI);

  logic                 selHit;
  logic [XB_ADDR_W-1:0] curAddr;
  logic                 curRsv;
  logic [XB_ADDR_W-1:0] pipeAddr;
  logic                 pipeRsv;
  logic                 pipeValid;

  assign selHit  = (devSel == 2'b00) && !selN;
  assign curAddr = {addrHi, addrLo};

  generate
    if (SHARE_EN) begin : g_rsv
      assign curRsv = (addrHi >= RSV_LO_V) && (addrHi <= RSV_HI_V);
    end else begin : g_norsv
      assign curRsv = 1'b0;
    end
  endgenerate

  // previous-cycle address, captured on every selected edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeAddr  <= '0;
      pipeRsv   <= 1'b0;
      pipeValid <= 1'b0;
    end else if (selHit) begin
      pipeAddr  <= curAddr;
      pipeRsv   <= curRsv;
      pipeValid <= 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn   = selHit && !dirRead && (curAddr != '0) && !curRsv;
    strobes.wrAddr = curAddr;
    strobes.rdAddr = pipeAddr;
    strobes.drive  = selHit && dirRead && pipeValid && !pipeRsv;
  end
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter bit SHARE_EN    = 1'b1,
  parameter int STATUS_ADDR = 1,
  parameter int STATUS_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xbStrobes_t           strobes,
  input  logic [XB_DATA_W-1:0] dataIn,
  output logic [XB_DATA_W-1:0] dataOut,
  output logic                 dataOe,
  output logic [STATUS_W-1:0]  statusOut
);
  logic [XB_DATA_W-1:0] regBank [XB_NUM_REGS];
  logic [XB_DATA_W-1:0] wrWord;
  logic [XB_DATA_W-1:0] rdWord;
  logic [XB_DATA_W-1:0] rdBus;

  // bus bit k carries logical bit (W-1-k)
  generate
    for (genvar k = 0; k < XB_DATA_W; k++) begin : g_swap
      assign wrWord[k] = dataIn[XB_DATA_W-1-k];
      assign rdBus[k]  = rdWord[XB_DATA_W-1-k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < XB_NUM_REGS; i++) regBank[i] <= '0;
    end else begin
      for (int i = 0; i < XB_NUM_REGS; i++) begin
        if (strobes.wrEn && (strobes.wrAddr == XB_ADDR_W'(i))) regBank[i] <= wrWord;
      end
    end
  end

  assign rdWord  = regBank[strobes.rdAddr];
  assign dataOe  = strobes.drive;
  assign dataOut = strobes.drive ? rdBus : '0;

  generate
    for (genvar s = 0; s < STATUS_W; s++) begin : g_stat
      if (SHARE_EN && (s == 1)) begin : g_held
        assign statusOut[s] = 1'b0;
      end else begin : g_live
        assign statusOut[s] = regBank[STATUS_ADDR][s];
      end
    end
  endgenerate
endmodule

// File: rtl/xbus_reg_slave.sv
module xbus_reg_slave
  import xbus_pkg::*;
#(
  parameter bit SHARE_EN    = 1'b1,
  parameter int RSV_LO      = 2,
  parameter int RSV_HI      = 3,
  parameter int STATUS_ADDR = 1,
  parameter int STATUS_W    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [XB_DATA_W-1:0]    dataIn,
  output logic [XB_DATA_W-1:0]    dataOut,
  output logic                    dataOe,
  input  logic [XB_ADDR_HI_W-1:0] addrHi,
  input  logic                    addrLo,
  input  logic                    dirRead,
  input  logic [1:0]              devSel,
  input  logic                    selN,
  output logic [STATUS_W-1:0]     statusOut,
  output logic                    irqN
);
  xbStrobes_t strobes;

  xbus_ctrl #(
    .SHARE_EN(SHARE_EN), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addrHi(addrHi), .addrLo(addrLo),
    .dirRead(dirRead), .devSel(devSel), .selN(selN), .strobes(strobes)
  );

  xbus_datapath #(
    .SHARE_EN(SHARE_EN), .STATUS_ADDR(STATUS_ADDR), .STATUS_W(STATUS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .statusOut(statusOut)
  );

  assign irqN = 1'b1;
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk
  import xbus_pkg::*;
#(
  parameter bit SHARE_EN = 1'b1,
  parameter int RSV_LO   = 2,
  parameter int RSV_HI   = 3,
  parameter int STATUS_W = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [XB_DATA_W-1:0]    dataOut,
  input logic                    dataOe,
  input logic [XB_ADDR_HI_W-1:0] addrHi,
  input logic                    addrLo,
  input logic                    dirRead,
  input logic [1:0]              devSel,
  input logic                    selN,
  input logic [STATUS_W-1:0]     statusOut
);
  logic sel;
  logic prevRsv;
  logic armed;

  assign sel = (devSel == 2'b00) && !selN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRsv <= 1'b0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (sel) prevRsv <= SHARE_EN && (int'(addrHi) >= RSV_LO) && (int'(addrHi) <= RSV_HI);
    end
  end

  // R6
  oe_sel_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (sel && dirRead)) else $error("driver on outside selected read");

  // R2
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> (!dataOe && dataOut == '0)) else $error("bus driven while unselected");

  // R8
  rsv_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    prevRsv |-> !dataOe) else $error("reserved address driven");

  // R7
  zero_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(sel && !dirRead && addrHi == '0 && !addrLo)) |-> $stable(statusOut))
    else $error("write to register 0 changed status");

  // R2
  unsel_status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!sel)) |-> $stable(statusOut)) else $error("status moved while unselected");

  generate
    if (SHARE_EN) begin : g_share
      // R9
      status1_low_chk: assert property (@(posedge clk) disable iff (!rstN)
        !statusOut[1]) else $error("shared status line driven");
    end
  endgenerate
endmodule

bind xbus_reg_slave xbus_chk #(
  .SHARE_EN(SHARE_EN), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI), .STATUS_W(STATUS_W)
) u_chk (.*);

// File: tb/tb_xbus_reg_slave.sv
`timescale 1ns/1ps
module tb_xbus_reg_slave;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic [3:0]  addrHi = '0;
  logic        addrLo = 1'b0;
  logic        dirRead = 1'b1;
  logic [1:0]  devSel = 2'b11;
  logic        selN = 1'b1;
  logic [3:0]  statusOut;
  logic        irqN;

  always #2 clk = ~clk;

  xbus_reg_slave dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .addrHi(addrHi), .addrLo(addrLo), .dirRead(dirRead), .devSel(devSel),
    .selN(selN), .statusOut(statusOut), .irqN(irqN)
  );

  int checks = 0;
  int errs = 0;

  typedef struct {
    bit          oe;
    logic [15:0] d;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [15:0] model [32];
  int prevAddr = 0;
  bit prevValid = 0;

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = v[15-k];
    return r;
  endfunction

  function automatic bit rsvAddr(input int a);
    return ((a >> 1) >= 2) && ((a >> 1) <= 3);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: sets one bus cycle at the falling edge, queues what must be seen
  task automatic busCycle(input logic [1:0] ds, input logic sn, input logic rd,
                          input int a, input logic [15:0] w, input string tag);
    expItem_t it;
    bit s;
    @(negedge clk);
    devSel = ds; selN = sn; dirRead = rd;
    addrHi = a[4:1]; addrLo = a[0]; dataIn = w;
    s = (ds == 2'b00) && !sn;
    it.oe  = s && rd && prevValid && !rsvAddr(prevAddr);
    it.d   = it.oe ? rev16(model[prevAddr]) : 16'h0;
    it.tag = tag;
    expQ.push_back(it);
    if (s) begin
      if (!rd && a != 0 && !rsvAddr(a)) model[a] = rev16(w);
      prevAddr = a;
      prevValid = 1;
    end
  endtask

  task automatic wr(input int a, input logic [15:0] w, input string tag);
    busCycle(2'b00, 1'b0, 1'b0, a, w, tag);
  endtask
  task automatic rd(input int a, input string tag);
    busCycle(2'b00, 1'b0, 1'b1, a, 16'h0, tag);
  endtask
  task automatic idle(input string tag);
    busCycle(2'b00, 1'b1, 1'b1, 0, 16'h0, tag);
  endtask

  function automatic logic [3:0] expStatus();
    logic [3:0] e;
    e = model[1][3:0];
    e[1] = 1'b0;
    return e;
  endfunction

  task automatic checkStatus(input string tag);
    #1;
    check(tag, 32'(statusOut), 32'(expStatus()));
  endtask

  // monitor: pops one expected item per driven cycle, before the next rising edge
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() != 0) begin
        it = expQ.pop_front();
        check({it.tag, " oe"}, 32'(dataOe), 32'(it.oe));
        check({it.tag, " data"}, 32'(dataOut), 32'(it.d));
      end
    end
  end

  initial begin
    #400000;
    checks++;
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 status at reset", 32'(statusOut), 32'h0);
    check("R1 driver at reset", 32'(dataOe), 32'h0);
    check("R10 irq in reset", 32'(irqN), 32'h1);
    @(negedge clk);
    rstN = 1'b1;

    rd(9, "R6 first read no prior cycle");
    rd(12, "R1 cleared register");
    rd(3, "R1 cleared register 12");

    wr(1, 16'h8000, "R11 write status reg");
    idle("R6 idle");
    checkStatus("R4 bus bit15 is bit0");
    wr(1, 16'hF000, "R11 write status reg");
    idle("R6 idle");
    checkStatus("R9 status1 held low");

    wr(0, 16'hFFFF, "R7 write reg0");
    idle("R6 idle");
    checkStatus("R7 status after reg0 write");
    rd(0, "R7 read after reg0");
    rd(0, "R7 reg0 reads zero");

    wr(8, 16'h5555, "R11 write 8");
    wr(9, 16'h1234, "R11 write 9");
    wr(10, 16'hABCD, "R11 write 10");
    rd(8, "R5 returns reg10");
    rd(9, "R3 returns reg8");
    rd(10, "R3 returns reg9");
    rd(17, "R5 returns reg10 again");
    rd(31, "R5 returns reg17");
    wr(10, 16'h0001, "R5 write then read");
    rd(10, "R5 prev was write");
    rd(2, "R5 new value of reg10");

    wr(5, 16'hFFFF, "R8 write reserved");
    rd(5, "R8 read reserved");
    rd(9, "R8 prev reserved no drive");
    rd(6, "R8 reg9 then reserved current");
    rd(9, "R8 prev reserved no drive 6");
    rd(5, "R8 reg9 returned");
    rd(7, "R8 prev reserved 5");
    rd(4, "R8 reserved 7");
    rd(9, "R8 reserved 4");

    busCycle(2'b01, 1'b0, 1'b0, 9, 16'h0F0F, "R2 devSel 01 write");
    busCycle(2'b10, 1'b0, 1'b1, 9, 16'h0, "R2 devSel 10 read");
    busCycle(2'b00, 1'b1, 1'b0, 1, 16'h0000, "R2 selN high write");
    busCycle(2'b11, 1'b0, 1'b0, 1, 16'h0000, "R2 devSel 11 write");
    idle("R6 idle");
    checkStatus("R2 status kept");
    rd(9, "R2 prev kept");
    rd(9, "R2 reg9 unchanged");

    rd(9, "R6 driving");
    idle("R6 released on deselect");
    wr(11, 16'h00FF, "R6 write no drive");
    rd(11, "R6 read after write");
    rd(11, "R4 roundtrip");

    repeat (3) @(negedge clk);
    #1;
    check("R10 irq high", 32'(irqN), 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule